// File: doc/BRIEF.md
# Single-Bus Microsequenced Integer Core

This block is a small multicycle processor in which every register-to-register transfer travels over one shared data bus. A hardwired step sequencer advances one step per clock. Each step picks exactly one bus source and the destination latches for that step. The datapath holds a program counter, a memory address latch, a memory data latch, an instruction latch, an operand latch (Y), a result latch (Z), a general register file and an adder.

Instructions are fetched from a simple read port. The port's latency is variable, and a completion strobe tells the sequencer when the read data is valid. The fetched word is classified by mask-and-compare rules. Two instruction kinds are executed: a three-register add and an add with a 16-bit immediate. Any word that matches no rule parks the core in a halt state, and the core stays there until reset.

A combinational observation port reads any general register. It exists so that results can be inspected without a store instruction.

Top module: `bus_seq_core`

## Requirements
- R1: After reset is released, `halted` is 0, the first read request goes to address 0, and `mem_rd` is 0 during reset.
- R2: Each fetch reads the word at the current PC, and the PC then advances by 4. Consecutive executed instructions are fetched from consecutive word addresses.
- R3: Once raised, `mem_rd` and `mem_addr` hold steady until `mem_done` is seen. `mem_rd` drops in the cycle after `mem_done`. Any read latency from 1 to 16 cycles, varying from one fetch to the next, is tolerated.
- R4: A word with bits 31:26 = 0, shamt (bits 10:6) = 0 and funct (bits 5:0) = 32 is an add. It writes rs (bits 25:21) + rt (bits 20:16) into rd (bits 15:11).
- R5: A word whose bits 31:26 equal 6'b001000 is an add-immediate. It writes rs + immediate (bits 15:0) into rt.
- R6: The immediate is sign-extended from bit 15 before the add.
- R7: Register 0 always reads as zero, and writes aimed at it are discarded.
- R8: A word that matches neither rule sets `halted`. `halted` then stays high and no further read is issued.
- R9: A completed add or add-immediate takes 6 + L cycles from the start of its read request to the start of the next one, where L is the number of cycles `mem_rd` was high before `mem_done`, counted inclusively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address of the pending read |
| mem_rd | output | 1 | Read request, held until completion |
| mem_rdata | input | 32 | Read data, valid with `mem_done` |
| mem_done | input | 1 | Read completion strobe |
| halted | output | 1 | Core stopped on an unrecognised word |
| dbg_sel | input | 5 | Register index for observation |
| dbg_rdata | output | 32 | Contents of the selected register |

## Verification
The hardest state to reach from the ports is a register holding a large value such as 0x10000000, because an immediate carries only 16 bits. The program therefore loads 0x1000 and then doubles the register sixteen times with self-adds. On that value it checks an immediate add and the fixed add encoding 0x012A5820. The memory model changes its latency on every fetch between 1, 16 and random values, so the stall step is exercised at both ends. The fetch period is compared against each latency in turn.

// File: rtl/bus_seq_core.sv
module bus_seq_core #(
  parameter int          DW         = 32,
  parameter int          NREG       = 32,
  parameter logic [31:0] ADD_MASK   = 32'hFC0007FF,
  parameter logic [31:0] ADD_MATCH  = 32'h00000020,
  parameter logic [31:0] ADDI_MASK  = 32'hFC000000,
  parameter logic [31:0] ADDI_MATCH = 32'h20000000,
  parameter int          STEP       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [DW-1:0]           mem_addr,
  output logic                    mem_rd,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_done,
  output logic                    halted,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DW-1:0]           dbg_rdata
);
  localparam int RW = $clog2(NREG);

  typedef enum logic [3:0] {F1, F2, F3, F4, A1, A2, A3, I1, I2, I3, HLT} step_t;
  step_t st;

  logic [DW-1:0] pc, mar, mdr, ir, y, z, bus;
  logic [DW-1:0] rf [NREG];
  logic          rd_pend;

  wire [RW-1:0] rs = ir[21 +: RW];
  wire [RW-1:0] rt = ir[16 +: RW];
  wire [RW-1:0] rd = ir[11 +: RW];
  wire [DW-1:0] rs_val = (rs == '0) ? '0 : rf[rs];
  wire [DW-1:0] rt_val = (rt == '0) ? '0 : rf[rt];
  wire [DW-1:0] imm_x  = {{(DW-16){ir[15]}}, ir[15:0]};
  wire [DW-1:0] sum    = y + bus;
  wire          is_add  = (ir & ADD_MASK)  == ADD_MATCH;
  wire          is_addi = (ir & ADDI_MASK) == ADDI_MATCH;
  wire          got     = rd_pend && mem_done;

  always_comb begin
    case (st)
      F1:         bus = pc;
      F2:         bus = DW'(STEP);
      F3:         bus = mdr;
      A1, I1:     bus = rs_val;
      A2:         bus = rt_val;
      I2:         bus = imm_x;
      default:    bus = z;
    endcase
  end

  assign mem_addr  = mar;
  assign mem_rd    = rd_pend;
  assign halted    = (st == HLT);
  assign dbg_rdata = (dbg_sel == '0) ? '0 : rf[dbg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F1; pc <= '0; mar <= '0; mdr <= '0; ir <= '0;
      y <= '0; z <= '0; rd_pend <= 1'b0;
    end else begin
      case (st)
        F1: begin mar <= bus; y <= bus; rd_pend <= 1'b1; st <= F2; end
        F2: begin
          z <= sum;
          if (got) begin mdr <= mem_rdata; rd_pend <= 1'b0; st <= F3; end
        end
        F3: begin ir <= bus; st <= F4; end
        F4: begin
          pc <= bus;
          st <= is_add ? A1 : (is_addi ? I1 : HLT);
        end
        A1: begin y <= bus; st <= A2; end
        A2: begin z <= sum; st <= A3; end
        I1: begin y <= bus; st <= I2; end
        I2: begin z <= sum; st <= I3; end
        A3, I3: st <= F1;
        default: st <= HLT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == A3 && rd != '0) rf[rd] <= bus;
    if (st == I3 && rt != '0) rf[rt] <= bus;
  end
endmodule

// File: rtl/bus_seq_core_chk.sv
module bus_seq_core_chk #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_done,
  input logic          halted,
  input logic [RW-1:0] dbg_sel,
  input logic [DW-1:0] dbg_rdata
);
  AST_RD_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) mem_rd && !mem_done |=> mem_rd);          // R3
  AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) mem_rd && !mem_done |=> $stable(mem_addr)); // R3
  AST_RD_DROP:     assert property (@(posedge clk) disable iff (!rst_n) mem_rd && mem_done |=> !mem_rd);          // R3
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted);                       // R8
  AST_HALT_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_rd);                      // R8
  AST_ZERO_REG:    assert property (@(posedge clk) disable iff (!rst_n) dbg_sel == '0 |-> dbg_rdata == '0);       // R7
endmodule

bind bus_seq_core bus_seq_core_chk #(.DW(DW), .RW(RW)) u_chk (.*);

// File: tb/sim_bus_seq_core.sv
module sim_bus_seq_core;
  logic        clk = 0, rst_n = 0;
  logic [31:0] mem_addr, mem_rdata = 0, dbg_rdata;
  logic        mem_rd, mem_done = 0, halted;
  logic [4:0]  dbg_sel = 0;

  bus_seq_core u0 (.clk, .rst_n, .mem_addr, .mem_rd, .mem_rdata, .mem_done,
                   .halted, .dbg_sel, .dbg_rdata);

  always #2.5 clk = ~clk;

  logic [31:0] mem [64];
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] exp_addr [$];
  logic [4:0]  exp_ridx [$];
  logic [31:0] exp_rval [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_fetch(int n);
    for (int i = 0; i < n; i++) exp_addr.push_back(32'(i * 4));
  endtask

  task automatic push_reg(logic [4:0] r, logic [31:0] v);
    exp_ridx.push_back(r); exp_rval.push_back(v);
  endtask

  always @(posedge clk) cyc++;

  int wcnt = 0, cur_lat = 1, prev_lat = 0, last_rise = -1, nfetch = 0;
  logic prev_rd = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1 rd low in reset", {31'b0, mem_rd}, 0);
    end else if (!mem_rd) begin
      wcnt = 0; mem_done = 0;
    end else begin
      if (!prev_rd) begin
        if (exp_addr.size() == 0) check("R2 unexpected fetch", mem_addr, 32'hFFFFFFFF);
        else check("R2 fetch address", mem_addr, exp_addr.pop_front());
        if (last_rise >= 0) check("R9 fetch period", 32'(cyc - last_rise), 32'(6 + prev_lat));
        last_rise = cyc;
        case (nfetch % 4)
          0: cur_lat = 16;
          1: cur_lat = 1;
          default: cur_lat = int'($urandom_range(16, 1));
        endcase
        prev_lat = cur_lat;
        nfetch++;
      end
      wcnt++;
      mem_done = (wcnt == cur_lat);
      mem_rdata = mem[mem_addr[7:2]];
    end
    prev_rd = mem_rd;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[0] = 32'h20091000;                          // addi $9,$0,0x1000
    for (int i = 1; i <= 16; i++) mem[i] = 32'h01294820; // add $9,$9,$9
    mem[17] = 32'h212A0050;                         // addi $10,$9,0x50
    mem[18] = 32'h012A5820;                         // add $11,$9,$10
    mem[19] = 32'h200CFFFF;                         // addi $12,$0,-1
    mem[20] = 32'h018B6820;                         // add $13,$12,$11
    mem[21] = 32'h01290020;                         // add $0,$9,$9
    mem[22] = 32'h21200005;                         // addi $0,$9,5
    mem[23] = 32'h012A5860;                         // shamt=1: unmatched
    push_fetch(24);
    push_reg(9,  32'h10000000); // R4 doubling chain
    push_reg(10, 32'h10000050); // R5
    push_reg(11, 32'h20000050); // R4 fixed encoding
    push_reg(12, 32'hFFFFFFFF); // R6
    push_reg(13, 32'h2000004F); // R4 R6
    push_reg(0,  32'h0);        // R7

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1 halted after reset", {31'b0, halted}, 0);

    while (!halted && cyc < 100000) @(posedge clk);
    @(negedge clk);
    if (!halted) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=halted");
    end
    check("R8 halted set", {31'b0, halted}, 1);
    check("R2 fetch count", 32'(nfetch), 24);
    while (exp_ridx.size() > 0) begin
      dbg_sel = exp_ridx.pop_front();
      #1;
      check($sformatf("R4/R5/R6/R7 reg %0d", dbg_sel), dbg_rdata, exp_rval.pop_front());
    end
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R8 no read after halt", {31'b0, mem_rd}, 0);
    check("R8 no extra fetch", 32'(nfetch), 24);
    check("R8 halted stays", {31'b0, halted}, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule